// File: doc/BRIEF.md
# Disjoint Routing Switch Box

This block sits at a channel crossing of an island-style logic fabric and joins four routing channels: left, right, top and bottom, each `TRACKS` wide (5 by default). The topology is disjoint. A signal on track index i can reach only track index i on the other three sides, so it never changes lanes. For every track, each ordered pair of distinct sides has its own enable bit, and each enable controls one direction only. The block therefore holds 12 enables per track, which is 60 bits at the default width.

The routing path is purely combinational. Each side has separate input and output buses. A side's output track is the OR of the same-index inputs from the other sides whose enable toward that side is set.

Configuration enters serially through a shift chain while `cfg_en_i` is high. A serial output allows several boxes to be chained. While loading, every routing output is held at 0. When `cfg_en_i` is low the stored enables stay fixed. Changing the channel width only requires a different `TRACKS` value, because the per-track crossbar is replicated.

Top module: `sb_switch_box`

## Requirements
- R1: The chain holds 12*TRACKS bits. On each rising clock edge with `cfg_en_i` high, one bit enters from `cfg_i`. After 12*TRACKS shifts, the first bit shifted in sits at index 0. The enable that routes source side s to destination side d on track t sits at index t*12 + s*3 + (d<s ? d : d-1), with side codes left=0, right=1, top=2, bottom=3.
- R2: With `cfg_en_i` low, output track t of side d equals the OR, over every other side s, of input track t of s ANDed with the enable s->d of track t. Several enabled sources merge.
- R3: An output on track t depends only on inputs on track t. No signal reaches a different track index.
- R4: Enables are directional. Setting s->d leaves d->s unrouted.
- R5: While `cfg_en_i` is high, all four output buses are 0 whatever the inputs.
- R6: While `cfg_en_i` is low, `cfg_i` is ignored and the stored enables, and therefore the routing, do not change.
- R7: `cfg_o` presents chain bit 0. While a new pattern loads, the k-th shift presents bit k of the previously loaded pattern before its edge, which supports daisy-chaining.
- R8: An active-low asynchronous reset `rst_ni` clears every enable, so all outputs read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration phase: shift enable, forces outputs to 0 |
| cfg_i | input | 1 | Serial configuration data in |
| cfg_o | output | 1 | Serial configuration data out (chain bit 0) |
| left_i | input | TRACKS | Left channel inputs |
| right_i | input | TRACKS | Right channel inputs |
| top_i | input | TRACKS | Top channel inputs |
| bottom_i | input | TRACKS | Bottom channel inputs |
| left_o | output | TRACKS | Left channel outputs |
| right_o | output | TRACKS | Right channel outputs |
| top_o | output | TRACKS | Top channel outputs |
| bottom_o | output | TRACKS | Bottom channel outputs |

## Verification
Two fixed straight-through paths (left to right and top to bottom) are driven with alternating, sparse and full-ones track patterns. This shows that each path carries its own channel and that the reverse directions stay dark. A single enable on one track, driven with all-ones inputs, separates a correct bit index and a correct track from a neighbouring one. Three sources converging on one side with disjoint bit patterns show OR merging. A one-way enable probed from both ends tells the two directions apart. Reloading a second pattern while watching the serial output confirms the chain order.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_SIDES       = 4;
  localparam int LINKS_PER_TRACK = NUM_SIDES * (NUM_SIDES - 1);

  localparam int SIDE_L = 0;
  localparam int SIDE_R = 1;
  localparam int SIDE_T = 2;
  localparam int SIDE_B = 3;

  // position of enable src->dst within one track's group of links
  function automatic int link_idx(input int src, input int dst);
    return src * (NUM_SIDES - 1) + ((dst < src) ? dst : dst - 1);
  endfunction
endpackage

// File: rtl/sb_cfg_chain.sv
module sb_cfg_chain #(
  parameter int unsigned LEN = 60
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_en_i,
  input  logic           ser_i,
  output logic           ser_o,
  output logic [LEN-1:0] bits_o
);
  logic [LEN-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q <= '0;
    else if (shift_en_i) q <= {ser_i, q[LEN-1:1]};
  end

  assign ser_o  = q[0];
  assign bits_o = q;

  assert_shift_in_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> q[LEN-1] == $past(ser_i));
  assert_shift_move_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> q[LEN-2:0] == $past(q[LEN-1:1]));
  assert_cfg_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(q));
endmodule

// File: rtl/sb_track_xbar.sv
module sb_track_xbar
  import sb_pkg::*;
(
  input  logic [NUM_SIDES-1:0]       in_i,
  input  logic [LINKS_PER_TRACK-1:0] en_i,
  output logic [NUM_SIDES-1:0]       out_o
);
  for (genvar d = 0; d < NUM_SIDES; d++) begin : g_dst
    logic [NUM_SIDES-1:0] terms;
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_src
      if (s == d) begin : g_self
        assign terms[s] = 1'b0;
      end else begin : g_link
        assign terms[s] = in_i[s] & en_i[link_idx(s, d)];
      end
    end
    assign out_o[d] = |terms;
  end
endmodule

// File: rtl/sb_switch_box.sv
module sb_switch_box
  import sb_pkg::*;
#(
  parameter int unsigned TRACKS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_en_i,
  input  logic              cfg_i,
  output logic              cfg_o,
  input  logic [TRACKS-1:0] left_i,
  input  logic [TRACKS-1:0] right_i,
  input  logic [TRACKS-1:0] top_i,
  input  logic [TRACKS-1:0] bottom_i,
  output logic [TRACKS-1:0] left_o,
  output logic [TRACKS-1:0] right_o,
  output logic [TRACKS-1:0] top_o,
  output logic [TRACKS-1:0] bottom_o
);
  localparam int unsigned CFG_BITS = TRACKS * LINKS_PER_TRACK;

  logic [CFG_BITS-1:0] cfg_bits;
  logic [TRACKS-1:0]   route_l, route_r, route_t, route_b;

  sb_cfg_chain #(.LEN(CFG_BITS)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (cfg_en_i),
    .ser_i      (cfg_i),
    .ser_o      (cfg_o),
    .bits_o     (cfg_bits)
  );

  for (genvar t = 0; t < TRACKS; t++) begin : g_track
    logic [NUM_SIDES-1:0] side_in, side_out;
    assign side_in[SIDE_L] = left_i[t];
    assign side_in[SIDE_R] = right_i[t];
    assign side_in[SIDE_T] = top_i[t];
    assign side_in[SIDE_B] = bottom_i[t];

    sb_track_xbar u_xbar (
      .in_i  (side_in),
      .en_i  (cfg_bits[t*LINKS_PER_TRACK +: LINKS_PER_TRACK]),
      .out_o (side_out)
    );

    assign route_l[t] = side_out[SIDE_L];
    assign route_r[t] = side_out[SIDE_R];
    assign route_t[t] = side_out[SIDE_T];
    assign route_b[t] = side_out[SIDE_B];

    // an active output needs a same-index driver on another side
    assert_lane_l_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      left_o[t] |-> (right_i[t] | top_i[t] | bottom_i[t]));
    assert_lane_r_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      right_o[t] |-> (left_i[t] | top_i[t] | bottom_i[t]));
    assert_lane_t_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      top_o[t] |-> (left_i[t] | right_i[t] | bottom_i[t]));
    assert_lane_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bottom_o[t] |-> (left_i[t] | right_i[t] | top_i[t]));
  end

  assign left_o   = cfg_en_i ? '0 : route_l;
  assign right_o  = cfg_en_i ? '0 : route_r;
  assign top_o    = cfg_en_i ? '0 : route_t;
  assign bottom_o = cfg_en_i ? '0 : route_b;

  assert_quiet_cfg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_en_i |-> ({left_o, right_o, top_o, bottom_o} == '0));
  assert_no_input_no_output_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({left_i, right_i, top_i, bottom_i} == '0) |-> ({left_o, right_o, top_o, bottom_o} == '0));
endmodule

// File: tb/sb_switch_box_tb.sv
module sb_switch_box_tb;
  localparam int W = 5;
  localparam int N = 12 * W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_en = 1'b0, cfg_in = 1'b0;
  logic cfg_out;
  logic [W-1:0] l_i = '0, r_i = '0, t_i = '0, b_i = '0;
  logic [W-1:0] l_o, r_o, t_o, b_o;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sb_switch_box #(.TRACKS(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en), .cfg_i(cfg_in), .cfg_o(cfg_out),
    .left_i(l_i), .right_i(r_i), .top_i(t_i), .bottom_i(b_i),
    .left_o(l_o), .right_o(r_o), .top_o(t_o), .bottom_o(b_o)
  );

  // {l_i, r_i, t_i, b_i, exp l_o, r_o, t_o, b_o} with L->R and T->B on all tracks
  localparam logic [39:0] VEC [4] = '{
    {5'b10101, 5'b11111, 5'b00000, 5'b11111, 5'b00000, 5'b10101, 5'b00000, 5'b00000},
    {5'b00000, 5'b00000, 5'b11011, 5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b11011},
    {5'b11111, 5'b11111, 5'b00100, 5'b11111, 5'b00000, 5'b11111, 5'b00000, 5'b00100},
    {5'b01010, 5'b10101, 5'b10001, 5'b01110, 5'b00000, 5'b01010, 5'b00000, 5'b10001}
  };

  // R1 index rule
  function automatic int idx(input int t, input int s, input int d);
    return t * 12 + s * 3 + ((d < s) ? d : d - 1);
  endfunction

  task automatic check(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic load(input logic [N-1:0] p, input bit chk_daisy, input logic [N-1:0] prev);
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = p[k];
      #1;
      if (chk_daisy) check("R7 daisy", {19'd0, cfg_out}, {19'd0, prev[k]});
    end
    @(negedge clk);
    cfg_en = 1'b0;
    #1;
  endtask

  task automatic drive(input logic [W-1:0] l, r, t, b);
    l_i = l; r_i = r; t_i = t; b_i = b;
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] cfg_a, cfg_b;
    logic [19:0]  snap;
    cfg_a = '0;
    for (int t = 0; t < W; t++) begin
      cfg_a[idx(t, 0, 1)] = 1'b1;
      cfg_a[idx(t, 2, 3)] = 1'b1;
    end

    // R8: reset state
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    drive('1, '1, '1, '1);
    check("R8 reset outputs", {l_o, r_o, t_o, b_o}, 20'd0);
    check("R8 reset cfg_o", {19'd0, cfg_out}, 20'd0);

    // R5: outputs forced low while loading
    @(negedge clk);
    cfg_en = 1'b1;
    #1;
    check("R5 quiet during cfg", {l_o, r_o, t_o, b_o}, 20'd0);
    load(cfg_a, 1'b0, '0);

    // R2/R4: table walk
    for (int v = 0; v < 4; v++) begin
      drive(VEC[v][39:35], VEC[v][34:30], VEC[v][29:25], VEC[v][24:20]);
      check("R2 R4 vector", {l_o, r_o, t_o, b_o}, VEC[v][19:0]);
    end

    // R5 again with a live configuration
    @(negedge clk);
    cfg_en = 1'b1;
    drive('1, '1, '1, '1);
    check("R5 quiet with config", {l_o, r_o, t_o, b_o}, 20'd0);
    cfg_en = 1'b0;
    #1;

    // R6: cfg_i toggling ignored when cfg_en low
    drive(5'b10110, 5'b0, 5'b01001, 5'b0);
    snap = {l_o, r_o, t_o, b_o};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cfg_in = ~cfg_in;
    end
    #1;
    check("R6 hold", {l_o, r_o, t_o, b_o}, snap);
    check("R6 hold value", snap, {5'b0, 5'b10110, 5'b0, 5'b01001});

    // R1/R3: single enable, track 2 left->top; R7 checks cfg_a streaming out
    cfg_b = '0;
    cfg_b[idx(2, 0, 2)] = 1'b1;
    load(cfg_b, 1'b1, cfg_a);
    drive('1, 5'b0, 5'b0, 5'b0);
    check("R1 R3 single lane", {l_o, r_o, t_o, b_o}, {5'b0, 5'b0, 5'b00100, 5'b0});
    drive(5'b11011, '1, '1, '1);
    check("R3 other lanes", {l_o, r_o, t_o, b_o}, 20'd0);

    // R1: top index, track 4 bottom->right = bit 58
    cfg_b = '0;
    cfg_b[58] = 1'b1;
    load(cfg_b, 1'b0, '0);
    drive(5'b0, 5'b0, 5'b0, '1);
    check("R1 bit 58", {l_o, r_o, t_o, b_o}, {5'b0, 5'b10000, 5'b0, 5'b0});

    // R2: merge right, top, bottom into left on every track
    cfg_b = '0;
    for (int t = 0; t < W; t++) begin
      cfg_b[idx(t, 1, 0)] = 1'b1;
      cfg_b[idx(t, 2, 0)] = 1'b1;
      cfg_b[idx(t, 3, 0)] = 1'b1;
    end
    load(cfg_b, 1'b0, '0);
    drive(5'b0, 5'b00011, 5'b01100, 5'b10000);
    check("R2 merge", {l_o, r_o, t_o, b_o}, {5'b11111, 15'd0});
    drive(5'b0, 5'b00001, 5'b0, 5'b00100);
    check("R2 partial merge", {l_o, r_o, t_o, b_o}, {5'b00101, 15'd0});

    // R4: right->left only
    cfg_b = '0;
    for (int t = 0; t < W; t++) cfg_b[idx(t, 1, 0)] = 1'b1;
    load(cfg_b, 1'b0, '0);
    drive('1, 5'b0, 5'b0, 5'b0);
    check("R4 reverse dark", {l_o, r_o, t_o, b_o}, 20'd0);
    drive(5'b0, 5'b10101, 5'b0, 5'b0);
    check("R4 forward", {l_o, r_o, t_o, b_o}, {5'b10101, 15'd0});

    // R8: async reset clears configuration
    #3 rst_ni = 1'b0;
    #2 rst_ni = 1'b1;
    #1;
    check("R8 reset clears", {l_o, r_o, t_o, b_o}, 20'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule